// File: doc/BRIEF.md
# Secure Debug Control Register

This block holds the 32-bit control word that the most privileged security tier uses to govern self-hosted debug, trace and performance-counter behaviour in the secure world. Software reaches it through a coprocessor-style system-register port. A request carries the coprocessor number, two opcode fields, two register-number fields, a read/write flag and write data. The block compares the encoding with its own. If the encoding matches, the block checks the current exception level and the trap-routing controls. It then either completes the access or reports an undefined-instruction or trap outcome together with a syndrome code.

The stored fields also drive a set of enable outputs for the current security state at all times: the debug-exception enables for secure privilege levels 1 and 0, the secure event-counting and trace enables, the secure cycle-counter prohibit, and the external-debugger blocking and trace-filter trap controls. These outputs feed the counters, the trace unit and the debug logic that sit around the block. The external authentication signal comes in as a plain input.

Top module: `sec_dbg_ctl`

## Requirements
- R1: Only bits 23, 21, 20, 19, 18, 17, 15 and 14 are stored. Every other bit reads back as 0, so writing 0xFFFFFFFF and reading it back returns 0x00BEC000.
- R2: After reset the stored word is 0, `rsp_valid` is 0, and every field-driven output takes the value that a zero word gives.
- R3: A request is served only when coproc=4'b1111, opc1=3'b000, crn=4'b0001, crm=4'b0011 and opc2=3'b001. Any other encoding produces no response and leaves the word unchanged.
- R4: Outcome codes on `rsp_code` are 0 ok, 1 undefined, 2 trap to level 2, 3 hypervisor trap and 4 trap to level 3. Requests from level 0 or level 2 are undefined. Requests from level 3 read or write the word.
- R5: A request from level 1 takes the first outcome that applies, in this order: code 2 if level 2 is enabled, 64-bit and its 64-bit trap bit is set; code 3 if level 2 is enabled, 32-bit and its 32-bit trap bit is set; code 2 if level 2 is 64-bit with NS=0 and EEL2=1; code 4 if level 3 is 64-bit with NS=0; otherwise code 1.
- R6: `rsp_syndrome` is 6'h03 for codes 2, 3 and 4, and 0 for codes 0 and 1.
- R7: A write from level 3 with NS=0 while `wr_lock` is high is undefined. Reads are not affected by `wr_lock`.
- R8: The word changes only on a matching write whose outcome is ok.
- R9: Outcome, syndrome and read data (0 unless the access is an ok read) appear together one clock after the request. `rsp_valid` is a one-cycle pulse.
- R10: In the secure state, the level-1 debug-exception enable follows the 2-bit field at [15:14]: 2'b10 forces it to 0, 2'b11 forces it to 1, and 2'b00 and the reserved 2'b01 both pass `auth_dbg_en` through.
- R11: In the secure state, the level-0 debug-exception enable is the level-1 enable ORed with `user_dbg_en`. In the non-secure state both enables are 1, whatever the field holds.
- R12: `sec_cyc_prohibit` is high only when `in_secure` is high and bit 23 is set. `ext_pmu_block`, `ext_dbg_block` and `trace_filt_trap` follow bits 21, 20 and 19.
- R13: `sec_pmu_en` and `sec_trace_en` follow bits 17 and 18. Both are forced to 1 when `in_secure` is high and `el3_present` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | Level 2 is enabled in the current state |
| el2_is_a64 | input | 1 | Level 2 runs the 64-bit state |
| el3_is_a64 | input | 1 | Level 3 runs the 64-bit state |
| el3_present | input | 1 | Level 3 is implemented |
| hyp_t1_a64 | input | 1 | Trap bit T1 of the 64-bit hypervisor control |
| hyp_t1_a32 | input | 1 | Trap bit T1 of the 32-bit hypervisor control |
| scr_ns | input | 1 | Security-control NS bit |
| scr_eel2 | input | 1 | Security-control secure-level-2 enable bit |
| wr_lock | input | 1 | Register-disable lock for secure writes |
| auth_dbg_en | input | 1 | Authentication-interface debug enable |
| user_dbg_en | input | 1 | Secure user-level debug enable |
| in_secure | input | 1 | Processor is in the secure state |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | Access outcome |
| rsp_syndrome | output | 6 | Trap syndrome code |
| rsp_rdata | output | 32 | Read data |
| sec_cyc_prohibit | output | 1 | Secure cycle-counter prohibit |
| ext_pmu_block | output | 1 | Block external-debugger access to counter registers |
| ext_dbg_block | output | 1 | Block external-debugger access to debug registers |
| trace_filt_trap | output | 1 | Trap lower-level trace-filter accesses |
| sec_trace_en | output | 1 | Effective secure trace enable |
| sec_pmu_en | output | 1 | Effective secure event-counting enable |
| dbg_exc_el1_en | output | 1 | Debug exceptions enabled at level 1 |
| dbg_exc_el0_en | output | 1 | Debug exceptions enabled at level 0 |

## Verification
The hardest case to reach is an access from level 1 where several trap conditions hold at once. Only the highest-priority condition may decide the outcome. A later rule must take effect only when every earlier rule fails for a reason that does not come from that later rule. The stimulus table therefore sets up contexts in which lower-priority traps are armed but must lose. Examples are a 32-bit trap bit set while level 2 is 64-bit, a 64-bit trap bit set while level 2 is disabled, and NS=0 together with EEL2=1 and level 3 in the 64-bit state. Each row also carries its expected code. The reserved field value 2'b01 and the write lock are covered by directed sequences that change the word and then read it back.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CODE_W   = 3;

  localparam int unsigned B_CYC_DIS  = 23;
  localparam int unsigned B_EXT_PMU  = 21;
  localparam int unsigned B_EXT_DBG  = 20;
  localparam int unsigned B_TRF_TRAP = 19;
  localparam int unsigned B_TRACE_EN = 18;
  localparam int unsigned B_PMU_EN   = 17;
  localparam int unsigned B_PDBG_LO  = 14;

  localparam logic [WORD_W-1:0] KEEP_MASK =
      (WORD_W'(1) << B_CYC_DIS)  | (WORD_W'(1) << B_EXT_PMU) |
      (WORD_W'(1) << B_EXT_DBG)  | (WORD_W'(1) << B_TRF_TRAP) |
      (WORD_W'(1) << B_TRACE_EN) | (WORD_W'(1) << B_PMU_EN) |
      (WORD_W'(3) << B_PDBG_LO);

  typedef enum logic [CODE_W-1:0] {
    OUT_OK       = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_L2  = 3'd2,
    OUT_HYP_TRAP = 3'd3,
    OUT_TRAP_L3  = 3'd4
  } outcome_e;

  function automatic logic enc_hit(input logic [3:0] cp, input logic [2:0] o1,
                                   input logic [3:0] n, input logic [3:0] m,
                                   input logic [2:0] o2);
    return (cp == 4'b1111) && (o1 == 3'b000) && (n == 4'b0001) &&
           (m == 4'b0011) && (o2 == 3'b001);
  endfunction

  function automatic logic is_trap(input logic [CODE_W-1:0] c);
    return (c == OUT_TRAP_L2) || (c == OUT_HYP_TRAP) || (c == OUT_TRAP_L3);
  endfunction

  // Reserved encoding 01 is folded onto 00 before any decision is taken.
  function automatic logic [1:0] pdbg_fold(input logic [1:0] f);
    return (f == 2'b01) ? 2'b00 : f;
  endfunction

  function automatic logic pdbg_level1(input logic [1:0] f, input logic auth);
    case (pdbg_fold(f))
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return auth;
    endcase
  endfunction

endpackage

// File: rtl/sdc_access_arbiter.sv
module sdc_access_arbiter
  import sdc_pkg::*;
(
  input  logic [1:0]        cur_el,
  input  logic              is_write,
  input  logic              el2_enabled,
  input  logic              el2_is_a64,
  input  logic              el3_is_a64,
  input  logic              hyp_t1_a64,
  input  logic              hyp_t1_a32,
  input  logic              scr_ns,
  input  logic              scr_eel2,
  input  logic              wr_lock,
  output logic [CODE_W-1:0] code_o
);

  outcome_e code;

  // Named terms of the level-1 chain, listed in priority order.
  logic l1_t_a64, l1_t_a32, l1_t_sel2, l1_t_l3;
  assign l1_t_a64  = el2_enabled && el2_is_a64 && hyp_t1_a64;
  assign l1_t_a32  = el2_enabled && !el2_is_a64 && hyp_t1_a32;
  assign l1_t_sel2 = el2_is_a64 && !scr_ns && scr_eel2;
  assign l1_t_l3   = el3_is_a64 && !scr_ns;

  logic l3_locked;
  assign l3_locked = is_write && !scr_ns && wr_lock;

  always_comb begin
    code = OUT_UNDEF;
    case (cur_el)
      2'd3: code = l3_locked ? OUT_UNDEF : OUT_OK;
      2'd1: begin
        if (l1_t_a64)       code = OUT_TRAP_L2;
        else if (l1_t_a32)  code = OUT_HYP_TRAP;
        else if (l1_t_sel2) code = OUT_TRAP_L2;
        else if (l1_t_l3)   code = OUT_TRAP_L3;
        else                code = OUT_UNDEF;
      end
      default: code = OUT_UNDEF;
    endcase
  end

  assign code_o = code;

endmodule

// File: rtl/sdc_field_store.sv
module sdc_field_store #(
  parameter int unsigned         W    = 32,
  parameter logic [W-1:0]        MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & MASK;
  end

  // R8: contents move only on a granted write
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/sdc_enable_derive.sv
module sdc_enable_derive (
  input  logic       in_secure,
  input  logic       el3_present,
  input  logic       auth_dbg_en,
  input  logic       user_dbg_en,
  input  logic       f_cyc_dis,
  input  logic       f_pmu_en,
  input  logic       f_trace_en,
  input  logic [1:0] f_pdbg,
  output logic       sec_cyc_prohibit,
  output logic       sec_pmu_en,
  output logic       sec_trace_en,
  output logic       dbg_exc_el1_en,
  output logic       dbg_exc_el0_en
);
  import sdc_pkg::*;

  logic force_on;
  logic s_el1;

  assign force_on         = in_secure && !el3_present;
  assign sec_cyc_prohibit = in_secure && f_cyc_dis;
  assign sec_pmu_en       = force_on || f_pmu_en;
  assign sec_trace_en     = force_on || f_trace_en;

  assign s_el1          = pdbg_level1(f_pdbg, auth_dbg_en);
  assign dbg_exc_el1_en = in_secure ? s_el1 : 1'b1;
  assign dbg_exc_el0_en = in_secure ? (s_el1 || user_dbg_en) : 1'b1;

endmodule

// File: rtl/sec_dbg_ctl.sv
module sec_dbg_ctl
  import sdc_pkg::*;
#(
  parameter int unsigned SYN_W    = 6,
  parameter int unsigned TRAP_SYN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_coproc,
  input  logic [2:0]        req_opc1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_opc2,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              el2_enabled,
  input  logic              el2_is_a64,
  input  logic              el3_is_a64,
  input  logic              el3_present,
  input  logic              hyp_t1_a64,
  input  logic              hyp_t1_a32,
  input  logic              scr_ns,
  input  logic              scr_eel2,
  input  logic              wr_lock,
  input  logic              auth_dbg_en,
  input  logic              user_dbg_en,
  input  logic              in_secure,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [31:0]       rsp_rdata,
  output logic              sec_cyc_prohibit,
  output logic              ext_pmu_block,
  output logic              ext_dbg_block,
  output logic              trace_filt_trap,
  output logic              sec_trace_en,
  output logic              sec_pmu_en,
  output logic              dbg_exc_el1_en,
  output logic              dbg_exc_el0_en
);

  localparam logic [SYN_W-1:0] SYN_TRAP = SYN_W'(TRAP_SYN);

  // Named internal events
  logic              ev_hit;
  logic [CODE_W-1:0] ev_code;
  logic              ev_grant;
  logic              ev_store_wr;
  logic [WORD_W-1:0] word_q;

  assign ev_hit      = req_valid && enc_hit(req_coproc, req_opc1, req_crn, req_crm, req_opc2);
  assign ev_grant    = ev_hit && (ev_code == OUT_OK);
  assign ev_store_wr = ev_grant && req_write;

  sdc_access_arbiter u_arb (
    .cur_el      (cur_el),
    .is_write    (req_write),
    .el2_enabled (el2_enabled),
    .el2_is_a64  (el2_is_a64),
    .el3_is_a64  (el3_is_a64),
    .hyp_t1_a64  (hyp_t1_a64),
    .hyp_t1_a32  (hyp_t1_a32),
    .scr_ns      (scr_ns),
    .scr_eel2    (scr_eel2),
    .wr_lock     (wr_lock),
    .code_o      (ev_code)
  );

  sdc_field_store #(.W(WORD_W), .MASK(KEEP_MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ev_store_wr),
    .wdata (req_wdata),
    .q     (word_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= OUT_OK;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= ev_hit;
      if (ev_hit) begin
        rsp_code     <= ev_code;
        rsp_syndrome <= is_trap(ev_code) ? SYN_TRAP : '0;
        rsp_rdata    <= (ev_grant && !req_write) ? word_q : '0;
      end
    end
  end

  assign ext_pmu_block   = word_q[B_EXT_PMU];
  assign ext_dbg_block   = word_q[B_EXT_DBG];
  assign trace_filt_trap = word_q[B_TRF_TRAP];

  sdc_enable_derive u_derive (
    .in_secure        (in_secure),
    .el3_present      (el3_present),
    .auth_dbg_en      (auth_dbg_en),
    .user_dbg_en      (user_dbg_en),
    .f_cyc_dis        (word_q[B_CYC_DIS]),
    .f_pmu_en         (word_q[B_PMU_EN]),
    .f_trace_en       (word_q[B_TRACE_EN]),
    .f_pdbg           (word_q[B_PDBG_LO+1:B_PDBG_LO]),
    .sec_cyc_prohibit (sec_cyc_prohibit),
    .sec_pmu_en       (sec_pmu_en),
    .sec_trace_en     (sec_trace_en),
    .dbg_exc_el1_en   (dbg_exc_el1_en),
    .dbg_exc_el0_en   (dbg_exc_el0_en)
  );

  // R1: read data never exposes reserved bits
  a_r1_rdata_res0: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~KEEP_MASK) == '0));

  // R3: non-matching requests are silent
  a_r3_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ev_hit) |=> !rsp_valid);

  // R4: lowest level is always undefined
  a_r4_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && cur_el == 2'd0) |=> (rsp_code == OUT_UNDEF));

  // R6: traps carry the fixed syndrome
  a_r6_trap_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code >= 3'd2) |-> (rsp_syndrome == SYN_TRAP));

  // R7: locked secure write is refused
  a_r7_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && req_write && cur_el == 2'd3 && !scr_ns && wr_lock) |=> (rsp_code == OUT_UNDEF));

  // R9: response follows a hit by one cycle
  a_r9_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid);

  // R12: cycle prohibit only in secure state
  a_r12_cyc_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
    !in_secure |-> !sec_cyc_prohibit);

endmodule

// File: tb/sec_dbg_ctl_tb_top.sv
`timescale 1ns/1ps
module sec_dbg_ctl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [3:0] req_coproc = 4'b1111, req_crn = 4'b0001, req_crm = 4'b0011;
  logic [2:0] req_opc1 = 3'b000, req_opc2 = 3'b001;
  logic [31:0] req_wdata = '0;
  logic [1:0] cur_el = 2'd3;
  logic el2_enabled = 0, el2_is_a64 = 0, el3_is_a64 = 0, el3_present = 1;
  logic hyp_t1_a64 = 0, hyp_t1_a32 = 0, scr_ns = 1, scr_eel2 = 0, wr_lock = 0;
  logic auth_dbg_en = 0, user_dbg_en = 0, in_secure = 0;

  logic rsp_valid;
  logic [2:0] rsp_code;
  logic [5:0] rsp_syndrome;
  logic [31:0] rsp_rdata;
  logic sec_cyc_prohibit, ext_pmu_block, ext_dbg_block, trace_filt_trap;
  logic sec_trace_en, sec_pmu_en, dbg_exc_el1_en, dbg_exc_el0_en;

  sec_dbg_ctl dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge.
  task automatic access(input logic wr, input logic [31:0] wd);
    req_valid = 1; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic ctx_l3;
    cur_el = 2'd3; scr_ns = 1; wr_lock = 0;
    el2_enabled = 0; el2_is_a64 = 0; el3_is_a64 = 0;
    hyp_t1_a64 = 0; hyp_t1_a32 = 0; scr_eel2 = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    ctx_l3();
    access(1'b0, '0);
    v = rsp_rdata;
  endtask

  task automatic wr(input logic [31:0] v);
    ctx_l3();
    access(1'b1, v);
  endtask

  // {el, wr, el2en, el2a64, el3a64, t1a64, t1a32, ns, eel2, lock, expected code}
  localparam int NV = 14;
  localparam logic [13:0] VECS [NV] = '{
    14'b00_0_1_1_1_1_1_0_0_0_001,
    14'b10_1_1_1_1_1_1_0_0_0_001,
    14'b01_0_1_1_0_1_0_1_0_0_010,
    14'b01_0_1_0_1_0_1_0_0_0_011,
    14'b01_0_1_1_1_0_1_0_0_0_100,
    14'b01_1_0_1_1_1_0_0_1_0_010,
    14'b01_0_0_1_1_0_0_1_1_0_001,
    14'b01_0_0_0_0_0_0_0_0_0_001,
    14'b01_0_1_0_1_0_0_0_0_0_100,
    14'b11_0_0_0_0_0_0_0_0_1_000,
    14'b11_1_0_0_0_0_0_0_0_1_001,
    14'b11_1_0_0_0_0_0_1_0_1_000,
    14'b11_1_0_0_0_0_0_0_0_0_000,
    14'b01_1_1_1_0_1_0_0_0_0_010
  };

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 rsp_valid at reset", {31'b0, rsp_valid}, 0);
    chk("R2 cyc prohibit at reset", {31'b0, sec_cyc_prohibit}, 0);
    chk("R2 ext blocks at reset", {29'b0, ext_pmu_block, ext_dbg_block, trace_filt_trap}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(v);
    chk("R2 word after reset", v, 32'h0);

    // R5 R4 R6 R7: table walk, all writes carry zero
    for (int i = 0; i < NV; i++) begin
      logic [13:0] t;
      t = VECS[i];
      cur_el = t[13:12]; el2_enabled = t[10]; el2_is_a64 = t[9]; el3_is_a64 = t[8];
      hyp_t1_a64 = t[7]; hyp_t1_a32 = t[6]; scr_ns = t[5]; scr_eel2 = t[4]; wr_lock = t[3];
      access(t[11], 32'h0);
      chk($sformatf("R9 valid vec %0d", i), {31'b0, rsp_valid}, 1);
      chk($sformatf("R5 code vec %0d", i), {29'b0, rsp_code}, {29'b0, t[2:0]});
      chk($sformatf("R6 syndrome vec %0d", i), {26'b0, rsp_syndrome}, (t[2:0] >= 3'd2) ? 32'h3 : 32'h0);
    end
    @(negedge clk);
    chk("R9 valid is a pulse", {31'b0, rsp_valid}, 0);

    // R1: reserved bits
    wr(32'hFFFF_FFFF);
    rd(v);
    chk("R1 masked readback", v, 32'h00BE_C000);
    chk("R12 ext pmu block", {31'b0, ext_pmu_block}, 1);
    chk("R12 ext dbg block", {31'b0, ext_dbg_block}, 1);
    chk("R12 trace filter trap", {31'b0, trace_filt_trap}, 1);
    in_secure = 0; #1;
    chk("R12 cyc prohibit non-secure", {31'b0, sec_cyc_prohibit}, 0);
    in_secure = 1; #1;
    chk("R12 cyc prohibit secure", {31'b0, sec_cyc_prohibit}, 1);

    // R8: trapped and locked writes leave word unchanged
    cur_el = 2'd1; el2_enabled = 1; el2_is_a64 = 1; hyp_t1_a64 = 1;
    access(1'b1, 32'h0);
    rd(v);
    chk("R8 trapped write ignored", v, 32'h00BE_C000);
    ctx_l3(); scr_ns = 0; wr_lock = 1;
    access(1'b1, 32'h0);
    chk("R7 locked write undefined", {29'b0, rsp_code}, 1);
    access(1'b0, 32'h0);
    chk("R7 locked read ok", {29'b0, rsp_code}, 0);
    chk("R7 locked read data", rsp_rdata, 32'h00BE_C000);

    // R3: non-matching encoding
    ctx_l3();
    req_crm = 4'b0010;
    access(1'b1, 32'h0);
    chk("R3 miss gives no response", {31'b0, rsp_valid}, 0);
    req_crm = 4'b0011;
    rd(v);
    chk("R3 miss leaves word", v, 32'h00BE_C000);

    // R10 R11: privileged debug field in secure state
    in_secure = 1;
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 2; a++) begin
        logic e1;
        wr(32'(s) << 14);
        auth_dbg_en = a[0]; user_dbg_en = 0; #1;
        e1 = (s == 2) ? 1'b0 : (s == 3) ? 1'b1 : a[0];
        chk($sformatf("R10 el1 spd=%0d auth=%0d", s, a), {31'b0, dbg_exc_el1_en}, {31'b0, e1});
        chk($sformatf("R11 el0 spd=%0d user=0", s), {31'b0, dbg_exc_el0_en}, {31'b0, e1});
        user_dbg_en = 1; #1;
        chk($sformatf("R11 el0 spd=%0d user=1", s), {31'b0, dbg_exc_el0_en}, 1);
      end
    end
    wr(32'h0000_8000);
    in_secure = 0; user_dbg_en = 0; #1;
    chk("R11 non-secure el1 enabled", {31'b0, dbg_exc_el1_en}, 1);
    chk("R11 non-secure el0 enabled", {31'b0, dbg_exc_el0_en}, 1);

    // R13: effective secure pmu/trace enables
    wr(32'h0);
    in_secure = 1; el3_present = 1; #1;
    chk("R13 pmu off with level 3", {31'b0, sec_pmu_en}, 0);
    chk("R13 trace off with level 3", {31'b0, sec_trace_en}, 0);
    el3_present = 0; #1;
    chk("R13 pmu forced without level 3", {31'b0, sec_pmu_en}, 1);
    chk("R13 trace forced without level 3", {31'b0, sec_trace_en}, 1);
    in_secure = 0; #1;
    chk("R13 pmu non-secure follows bit", {31'b0, sec_pmu_en}, 0);
    el3_present = 1;
    wr(32'h0002_0000);
    chk("R13 pmu follows bit 17", {31'b0, sec_pmu_en}, 1);
    chk("R13 trace follows bit 18", {31'b0, sec_trace_en}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule